// File: doc/BRIEF.md
# Latched-Address One-of-N Line Decoder

This block turns a binary address into a single asserted line out of `2**ADDR_W` select lines (eight by default). The address passes through a holding stage: while the hold input is low the stage follows the address pins, and while it is high the decoder keeps working from the address captured on the last clock edge at which hold was low. Two chip selects of opposite polarity gate the result. The block is enabled only when the active-high select is 1 and the active-low select is 0. Any other pair forces every line to its idle level. The gating sits after the holding stage, so the selects act on the outputs at once even while an address is held.

With one select held at its enabling level, the other select carries a data bit. The addressed line then repeats that bit, true or inverted depending on which select carries it, so the block works as a one-to-N demultiplexer. `ACTIVE_LOW_OUT` picks the output polarity. `ADDR_W` sets the width, and a wider decoder can be built by feeding upper address bits to the selects of several instances. `MODE` picks the holding stage:
- `LATCH_FOLLOW_LIVE` bypasses the register while hold is low, so the stage is transparent in the same cycle.
- `LATCH_REGISTERED` is fully synchronous and decodes only the register, so a new address shows one cycle later.

Top module: `latched_decoder`

## Requirements
- R1: When enabled, exactly one line is asserted, the one whose index equals the effective address. With `ACTIVE_LOW_OUT`=1, the asserted line is 0 and every other line is 1.
- R2: When `sel_hi_i` is 0 or `sel_lo_n_i` is 1, no line is asserted (all 1 with `ACTIVE_LOW_OUT`=1), whatever the address or hold state.
- R3: In `LATCH_FOLLOW_LIVE` mode with `hold_i`=0, the effective address is `addr_i` in the same cycle.
- R4: With `hold_i`=1, the effective address is the value of `addr_i` at the last rising clock edge where `hold_i` was 0. Address changes while `hold_i`=1 have no effect on the outputs.
- R5: A change of either select changes the outputs in the same cycle while an address is held, and the held address is kept across it.
- R6: With `sel_lo_n_i`=0 and `sel_hi_i` carrying data, the addressed line equals the inverted data (active-low lines). With `sel_hi_i`=1 and `sel_lo_n_i` carrying data, the addressed line equals the data. Unaddressed lines stay idle.
- R7: With `ACTIVE_LOW_OUT`=0, the asserted line is 1, all others are 0, and a disabled block drives all 0.
- R8: In `LATCH_REGISTERED` mode, the effective address is always the held register. An address applied with `hold_i`=0 reaches the outputs after the next rising clock edge.
- R9: Reset clears the held address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address-holding register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held address |
| addr_i | input | ADDR_W | Binary address |
| hold_i | input | 1 | 1 keeps the stored address, 0 lets it follow `addr_i` |
| sel_hi_i | input | 1 | Active-high chip select |
| sel_lo_n_i | input | 1 | Active-low chip select |
| line_o | output | 2**ADDR_W | Decoded select lines, polarity set by `ACTIVE_LOW_OUT` |

## Verification
The bench builds two instances at `ADDR_W`=3. One uses the defaults: active-low lines with a transparent holding stage. The other is built with `ACTIVE_LOW_OUT`=0 and `LATCH_REGISTERED`. The instances see the same stimulus, so one run compares same-cycle transparency against the one-cycle registered lag, and true against inverted demultiplexed data. Every address is crossed with all four select pairs and both hold levels. The bench also runs held-value sequences with moving addresses, select toggles under hold, and fixed-seed random traffic.

// File: rtl/latched_decoder_pkg.sv
package latched_decoder_pkg;

  // Variant of the address-holding stage
  typedef enum logic {
    LATCH_FOLLOW_LIVE = 1'b0,  // hold low: decode the live address in the same cycle
    LATCH_REGISTERED  = 1'b1   // always decode the register: one-cycle lag
  } latch_mode_e;

  // Opposite-polarity select pair: enabled only for high/low
  function automatic logic select_on(input logic hi, input logic lo_n);
    return hi & ~lo_n;
  endfunction

  // Map a "line is hit" flag onto the output polarity
  function automatic logic drive_level(input logic hit, input logic active_low);
    return active_low ? ~hit : hit;
  endfunction

endpackage

// File: rtl/ldec_addr_stage.sv
module ldec_addr_stage
  import latched_decoder_pkg::*;
#(
  parameter int          ADDR_W = 3,
  parameter latch_mode_e MODE   = LATCH_FOLLOW_LIVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_i,
  output logic [ADDR_W-1:0] held_q_o,
  output logic [ADDR_W-1:0] eff_addr_o
);

  logic [ADDR_W-1:0] held_q;

  // The register loads whenever hold is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (!hold_i) begin
      held_q <= addr_i;
    end
  end

  assign held_q_o = held_q;

  generate
    if (MODE == LATCH_FOLLOW_LIVE) begin : g_follow
      // Bypass restores same-cycle transparency while hold is low
      assign eff_addr_o = hold_i ? held_q : addr_i;
    end else begin : g_registered
      assign eff_addr_o = held_q;
    end
  endgenerate

endmodule

// File: rtl/ldec_select_gate.sv
module ldec_select_gate
  import latched_decoder_pkg::*;
(
  input  logic sel_hi_i,
  input  logic sel_lo_n_i,
  output logic enable_o
);

  assign enable_o = select_on(sel_hi_i, sel_lo_n_i);

endmodule

// File: rtl/ldec_line_drive.sv
module ldec_line_drive
  import latched_decoder_pkg::*;
#(
  parameter int ADDR_W         = 3,
  parameter bit ACTIVE_LOW_OUT = 1'b1,
  localparam int OUT_W         = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] eff_addr_i,
  input  logic              enable_i,
  output logic [OUT_W-1:0]  line_o
);

  // One comparator per line: each line is a shallow equality plus the gate
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic hit;
    assign hit       = enable_i && (eff_addr_i == IDX);
    assign line_o[i] = drive_level(hit, ACTIVE_LOW_OUT);
  end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder
  import latched_decoder_pkg::*;
#(
  parameter int          ADDR_W         = 3,
  parameter bit          ACTIVE_LOW_OUT = 1'b1,
  parameter latch_mode_e MODE           = LATCH_FOLLOW_LIVE,
  localparam int         OUT_W          = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_i,
  input  logic              sel_hi_i,
  input  logic              sel_lo_n_i,
  output logic [OUT_W-1:0]  line_o
);

  // Named internal events, visible to the bound checker
  logic [ADDR_W-1:0] held_q;
  logic [ADDR_W-1:0] eff_addr;
  logic              enable_w;

  ldec_addr_stage #(
    .ADDR_W (ADDR_W),
    .MODE   (MODE)
  ) addr_stage_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .hold_i     (hold_i),
    .held_q_o   (held_q),
    .eff_addr_o (eff_addr)
  );

  ldec_select_gate sel_gate_i (
    .sel_hi_i   (sel_hi_i),
    .sel_lo_n_i (sel_lo_n_i),
    .enable_o   (enable_w)
  );

  ldec_line_drive #(
    .ADDR_W         (ADDR_W),
    .ACTIVE_LOW_OUT (ACTIVE_LOW_OUT)
  ) line_drive_i (
    .eff_addr_i (eff_addr),
    .enable_i   (enable_w),
    .line_o     (line_o)
  );

endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
  parameter int  ADDR_W         = 3,
  parameter bit  ACTIVE_LOW_OUT = 1'b1,
  parameter bit  REGISTERED     = 1'b0,
  localparam int OUT_W          = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              hold_i,
  input logic              sel_hi_i,
  input logic              sel_lo_n_i,
  input logic [OUT_W-1:0]  line_o,
  input logic [ADDR_W-1:0] held_q
);

  logic [OUT_W-1:0] asserted_v;
  logic             on_w;

  always_comb begin
    asserted_v = ACTIVE_LOW_OUT ? ~line_o : line_o;
    on_w       = sel_hi_i && !sel_lo_n_i;
  end

  AST_ONE_LINE_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    on_w |-> $countones(asserted_v) == 1);  // R1

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !on_w |-> asserted_v == '0);  // R2

  AST_LIVE_ADDR_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    (on_w && !hold_i && !REGISTERED) |-> asserted_v[addr_i]);  // R3

  AST_HELD_ADDR_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    (on_w && (hold_i || REGISTERED)) |-> asserted_v[held_q]);  // R4

  AST_HOLD_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(held_q));  // R4

  AST_CAPTURE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> held_q == $past(addr_i));  // R8

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> held_q == '0);  // R9

endmodule

bind latched_decoder latched_decoder_chk #(
  .ADDR_W         (ADDR_W),
  .ACTIVE_LOW_OUT (ACTIVE_LOW_OUT),
  .REGISTERED     (MODE == latched_decoder_pkg::LATCH_REGISTERED)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .hold_i     (hold_i),
  .sel_hi_i   (sel_hi_i),
  .sel_lo_n_i (sel_lo_n_i),
  .line_o     (line_o),
  .held_q     (held_q)
);

// File: tb/latched_decoder_tb_top.sv
module latched_decoder_tb_top;

  localparam int AW = 3;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          hold = 1'b1;
  logic          s_hi = 1'b0;
  logic          s_lo_n = 1'b1;
  logic [NW-1:0] line_a;
  logic [NW-1:0] line_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [AW-1:0] held_model = '0;

  always #4 clk = ~clk;  // 125 MHz

  // Default build: active-low lines, transparent stage
  latched_decoder #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .hold_i(hold),
    .sel_hi_i(s_hi), .sel_lo_n_i(s_lo_n), .line_o(line_a));

  // Active-high lines, fully registered stage
  latched_decoder #(
    .ADDR_W(AW), .ACTIVE_LOW_OUT(1'b0),
    .MODE(latched_decoder_pkg::LATCH_REGISTERED)
  ) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .hold_i(hold),
    .sel_hi_i(s_hi), .sel_lo_n_i(s_lo_n), .line_o(line_b));

  // Expected line vector from the requirements
  function automatic logic [NW-1:0] expect_lines(input logic [AW-1:0] a,
      input logic hi, input logic lo_n, input bit act_low);
    logic [NW-1:0] r;
    for (int i = 0; i < NW; i++) begin
      bit on;
      on = (hi == 1'b1) && (lo_n == 1'b0) && (int'(a) == i);
      r[i] = act_low ? !on : on;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [NW-1:0] got,
      input logic [NW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  // Drive at negedge, compare 1 ns later, then advance the holding model
  task automatic step(input logic [AW-1:0] a, input logic h, input logic hi,
      input logic lo_n, input string tag);
    logic [AW-1:0] eff_a;
    @(negedge clk);
    addr = a; hold = h; s_hi = hi; s_lo_n = lo_n;
    #1;
    eff_a = h ? held_model : a;
    check(tag, line_a, expect_lines(eff_a, hi, lo_n, 1'b1));
    check("R7,R8", line_b, expect_lines(held_model, hi, lo_n, 1'b0));
    @(posedge clk);
    if (!h) held_model = a;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0137);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: held register starts at zero, hold keeps it despite address 5
    step(3'd5, 1'b1, 1'b1, 1'b0, "R9");
    step(3'd6, 1'b1, 1'b1, 1'b0, "R9");
    // Every address x every select pair x both hold levels
    for (int a = 0; a < NW; a++) begin
      for (int sp = 0; sp < 4; sp++) begin
        logic hi, lo_n;
        hi = sp[1]; lo_n = sp[0];
        step(AW'(a), 1'b0, hi, lo_n, (hi && !lo_n) ? "R1,R3" : "R2");
        step(AW'(a), 1'b0, hi, lo_n, (hi && !lo_n) ? "R1,R3" : "R2");
        step(AW'(NW - 1 - a), 1'b1, hi, lo_n, (hi && !lo_n) ? "R4" : "R2");
      end
    end
    // Held value survives a stream of address changes
    step(3'd2, 1'b0, 1'b1, 1'b0, "R3");
    for (int a = 0; a < NW; a++) step(AW'(a), 1'b1, 1'b1, 1'b0, "R4");
    // Selects act during hold, held address kept afterwards
    step(3'd7, 1'b0, 1'b1, 1'b0, "R3");
    step(3'd1, 1'b1, 1'b0, 1'b0, "R5");
    step(3'd4, 1'b1, 1'b1, 1'b1, "R5");
    step(3'd0, 1'b1, 1'b1, 1'b0, "R5");
    // Demultiplexing: data on one select, other held enabling
    step(3'd3, 1'b0, 1'b1, 1'b0, "R6");
    for (int k = 0; k < 6; k++) step(3'd3, 1'b1, k[0], 1'b0, "R6");
    for (int k = 0; k < 6; k++) step(3'd3, 1'b1, 1'b1, k[0], "R6");
    // Fixed-seed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] ra;
      logic rh, rhi, rlo;
      ra = AW'($urandom());
      rh = ($urandom() % 3) == 0;
      rhi = ($urandom() % 4) != 0;
      rlo = ($urandom() % 4) == 0;
      step(ra, rh, rhi, rlo, rh ? "R4" : "R3");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule